// File: doc/BRIEF.md
# Segmented Page Translation Buffer

This block turns a 32-bit effective address into a physical address for 4 KB pages. The top nibble of the effective address picks one of sixteen segment registers. Each segment register holds a 24-bit virtual segment identifier and a no-execute flag. The identifier replaces that nibble, which gives a 52-bit virtual address. Its 40-bit virtual page number is looked up in a 128-entry translation buffer, organised as 64 sets of two ways. The 12-bit page offset passes through untranslated.

A lookup request carries the effective address, the access kind and the privilege level. The answer appears one cycle later. It is either a hit with the physical address, a protection fault, or a miss. A miss raises a page-walk request and presents the virtual page number. The walk itself happens outside this block. Its result comes back through the refill port. An invalidate port empties one set. Hits maintain per-entry referenced and changed bits and pulse an update strobe when one of them changes.

Top module: `mmu_page_xlate`

## Requirements
- R1: Effective address bits 31:28 select the segment register. The virtual page number on `rsp_vpn` is {segment identifier, effective address bits 27:12}. A segment write takes effect for lookups issued in the following cycle.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: On a hit, `rsp_pa` is {stored physical page number, effective address bits 11:0}.
- R4: The set is effective address bits 19:14. Two pages with different virtual page numbers in the same set are held at once, one per way, and both hit.
- R5: A lookup that matches no valid entry and is not a no-execute fault gives `rsp_walk`=1, `rsp_hit`=0 and `rsp_fault`=0.
- R6: A fetch (`req_kind`=0) through a segment whose no-execute flag is set gives `rsp_fault`=1 and `rsp_walk`=0, whether or not the page is held. A load (`req_kind`=1) through the same segment is not faulted.
- R7: A hit faults when `req_user`=1 and the entry is supervisor-only, or when a store (`req_kind`=2) reaches a read-only entry. A faulting access changes no referenced, changed or replacement state.
- R8: A refill writes the lowest-numbered invalid way of its set. If both ways are valid, it writes the least recently used way. Hits and refills both count as a use.
- R9: A non-faulting hit sets the referenced bit. A non-faulting store hit also sets the changed bit. `rc_upd` pulses with the response whenever either bit goes from 0 to 1, and `rc_ref`/`rc_chg` then show the new values.
- R10: An invalidate request clears both ways of the set it names.
- R11: After reset every entry is invalid, every segment register is zero with no-execute clear, and all response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr_en | input | 1 | Write one segment register |
| seg_wr_idx | input | 4 | Segment register number |
| seg_wr_vsid | input | 24 | Segment identifier to write |
| seg_wr_nx | input | 1 | No-execute flag to write |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 treated as load |
| req_user | input | 1 | 1 for user privilege |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | 40 | Virtual page number of the refill |
| fill_ppn | input | 20 | Physical page number of the refill |
| fill_sup_only | input | 1 | Entry is supervisor-only |
| fill_rd_only | input | 1 | Entry is read-only |
| inv_valid | input | 1 | Invalidate request |
| inv_set | input | 6 | Set to invalidate |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Usable translation found |
| rsp_fault | output | 1 | Protection or no-execute fault |
| rsp_walk | output | 1 | Miss, page walk requested |
| rsp_vpn | output | 40 | Virtual page number of the request |
| rsp_pa | output | 32 | Physical address on a hit |
| rc_upd | output | 1 | Referenced/changed bits of the hit entry changed |
| rc_ref | output | 1 | New referenced bit |
| rc_chg | output | 1 | New changed bit |

## Verification
The bench builds the block with its default geometry: 16 segments, 64 sets of two ways and 4 KB pages. The random addresses are limited to four sets, four upper tag values, all four in-page tag bits and a pool of four segment identifiers. This keeps every set under constant eviction pressure, so replacement order, aliasing across segments and refills into full sets happen often. Directed sequences pin the no-execute, privilege and read-only faults, the once-only changed strobe, and both-way invalidation.

// File: rtl/mmu_xlate_pkg.sv
package mmu_xlate_pkg;

    localparam int EA_W      = 32;
    localparam int OFF_W     = 12;
    localparam int SEG_SEL_W = 4;
    localparam int VSID_W    = 24;
    localparam int SET_W     = 6;
    localparam int IDX_LO    = 14;
    localparam int N_WAYS    = 2;   // replacement state is one bit per set

    localparam int N_SEGS  = 1 << SEG_SEL_W;
    localparam int N_SETS  = 1 << SET_W;
    localparam int PPN_W   = EA_W - OFF_W;
    localparam int PIDX_W  = EA_W - SEG_SEL_W - OFF_W;
    localparam int VPN_W   = VSID_W + PIDX_W;
    localparam int TAG_W   = VPN_W - SET_W;
    localparam int WAY_W   = $clog2(N_WAYS);
    localparam int SET_POS = IDX_LO - OFF_W;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_OTHER = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
        logic              sup_only;
        logic              rd_only;
        logic              refd;
        logic              chgd;
    } tlb_ent_t;

    typedef struct packed {
        logic [VSID_W-1:0] vsid;
        logic              nx;
    } seg_ent_t;

    typedef struct packed {
        logic              vld;
        logic              hit;
        logic              fault;
        logic              walk;
        logic [VPN_W-1:0]  vpn;
        logic [EA_W-1:0]   pa;
        logic              upd;
        logic              refd;
        logic              chgd;
    } rsp_t;

    function automatic logic [SET_W-1:0] vpn_set(input logic [VPN_W-1:0] vpn);
        return vpn[SET_POS +: SET_W];
    endfunction

    function automatic logic [TAG_W-1:0] vpn_tag(input logic [VPN_W-1:0] vpn);
        return {vpn[VPN_W-1:SET_POS+SET_W], vpn[SET_POS-1:0]};
    endfunction

endpackage

// File: rtl/mmu_seg_file.sv
module mmu_seg_file
    import mmu_xlate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEG_SEL_W-1:0] wr_idx,
    input  logic [VSID_W-1:0]    wr_vsid,
    input  logic                 wr_nx,
    input  logic [SEG_SEL_W-1:0] rd_idx,
    output logic [VSID_W-1:0]    rd_vsid,
    output logic                 rd_nx
);

    typedef struct packed {
        seg_ent_t [N_SEGS-1:0] seg;
    } seg_state_t;

    seg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.seg[wr_idx].vsid = wr_vsid;
            st_d.seg[wr_idx].nx   = wr_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_vsid = st_q.seg[rd_idx].vsid;
    assign rd_nx   = st_q.seg[rd_idx].nx;

endmodule

// File: rtl/mmu_tlb_store.sv
module mmu_tlb_store
    import mmu_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    // lookup read
    input  logic [SET_W-1:0]  lk_set,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [WAY_W-1:0]  lk_way,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic              lk_sup_only,
    output logic              lk_rd_only,
    output logic              lk_refd,
    output logic              lk_chgd,
    // refill
    input  logic              fill_en,
    input  logic [SET_W-1:0]  fill_set,
    input  tlb_ent_t          fill_ent,
    // set invalidate
    input  logic              inv_en,
    input  logic [SET_W-1:0]  inv_set,
    // hit bookkeeping
    input  logic              touch_en,
    input  logic [SET_W-1:0]  touch_set,
    input  logic [WAY_W-1:0]  touch_way,
    input  logic              touch_chg
);

    typedef struct packed {
        tlb_ent_t [N_SETS-1:0][N_WAYS-1:0] ent;
        logic     [N_SETS-1:0]             lru;
    } store_t;

    store_t              st_d, st_q;
    logic [N_WAYS-1:0]   way_match;
    logic [WAY_W-1:0]    fill_way;
    logic                fill_found;
    tlb_ent_t            sel_ent;

    generate
        for (genvar w = 0; w < N_WAYS; w++) begin : g_cmp
            assign way_match[w] = st_q.ent[lk_set][w].vld &&
                                  (st_q.ent[lk_set][w].tag == lk_tag);
        end
    endgenerate

    always_comb begin
        lk_way = '0;
        for (int w = N_WAYS - 1; w >= 0; w--) begin
            if (way_match[w]) lk_way = WAY_W'(w);
        end
        lk_hit      = |way_match;
        sel_ent     = st_q.ent[lk_set][lk_way];
        lk_ppn      = sel_ent.ppn;
        lk_sup_only = sel_ent.sup_only;
        lk_rd_only  = sel_ent.rd_only;
        lk_refd     = sel_ent.refd;
        lk_chgd     = sel_ent.chgd;
    end

    // victim: first empty way, otherwise the way marked least recently used
    always_comb begin
        fill_way   = st_q.lru[fill_set];
        fill_found = 1'b0;
        for (int w = 0; w < N_WAYS; w++) begin
            if (!fill_found && !st_q.ent[fill_set][w].vld) begin
                fill_way   = WAY_W'(w);
                fill_found = 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (touch_en && !(fill_en && fill_set == touch_set)
                     && !(inv_en && inv_set == touch_set)) begin
            st_d.ent[touch_set][touch_way].refd = 1'b1;
            st_d.ent[touch_set][touch_way].chgd =
                st_q.ent[touch_set][touch_way].chgd | touch_chg;
            st_d.lru[touch_set] = ~touch_way;
        end
        if (fill_en) begin
            st_d.ent[fill_set][fill_way]     = fill_ent;
            st_d.ent[fill_set][fill_way].vld = 1'b1;
            st_d.lru[fill_set]               = ~fill_way;
        end
        if (inv_en) begin
            for (int w = 0; w < N_WAYS; w++) begin
                st_d.ent[inv_set][w].vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/mmu_page_xlate.sv
module mmu_page_xlate
    import mmu_xlate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seg_wr_en,
    input  logic [SEG_SEL_W-1:0] seg_wr_idx,
    input  logic [VSID_W-1:0]    seg_wr_vsid,
    input  logic                 seg_wr_nx,
    input  logic                 req_valid,
    input  logic [EA_W-1:0]      req_ea,
    input  logic [1:0]           req_kind,
    input  logic                 req_user,
    input  logic                 fill_valid,
    input  logic [VPN_W-1:0]     fill_vpn,
    input  logic [PPN_W-1:0]     fill_ppn,
    input  logic                 fill_sup_only,
    input  logic                 fill_rd_only,
    input  logic                 inv_valid,
    input  logic [SET_W-1:0]     inv_set,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_fault,
    output logic                 rsp_walk,
    output logic [VPN_W-1:0]     rsp_vpn,
    output logic [EA_W-1:0]      rsp_pa,
    output logic                 rc_upd,
    output logic                 rc_ref,
    output logic                 rc_chg
);

    logic [VSID_W-1:0] seg_rd_vsid;
    logic              seg_rd_nx;
    logic [VPN_W-1:0]  req_vpn;
    logic              lk_hit;
    logic [WAY_W-1:0]  lk_way;
    logic [PPN_W-1:0]  lk_ppn;
    logic              lk_sup_only, lk_rd_only, lk_refd, lk_chgd;
    logic              is_fetch, is_store;
    logic              nx_fault, prot_fault, good_hit;
    tlb_ent_t          fill_ent;
    rsp_t              rsp_d, rsp_q;

    mmu_seg_file u_segs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_idx  (seg_wr_idx),
        .wr_vsid (seg_wr_vsid),
        .wr_nx   (seg_wr_nx),
        .rd_idx  (req_ea[EA_W-1 -: SEG_SEL_W]),
        .rd_vsid (seg_rd_vsid),
        .rd_nx   (seg_rd_nx)
    );

    assign req_vpn = {seg_rd_vsid, req_ea[EA_W-SEG_SEL_W-1:OFF_W]};

    always_comb begin
        fill_ent          = '0;
        fill_ent.vld      = 1'b1;
        fill_ent.tag      = vpn_tag(fill_vpn);
        fill_ent.ppn      = fill_ppn;
        fill_ent.sup_only = fill_sup_only;
        fill_ent.rd_only  = fill_rd_only;
    end

    mmu_tlb_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_set      (vpn_set(req_vpn)),
        .lk_tag      (vpn_tag(req_vpn)),
        .lk_hit      (lk_hit),
        .lk_way      (lk_way),
        .lk_ppn      (lk_ppn),
        .lk_sup_only (lk_sup_only),
        .lk_rd_only  (lk_rd_only),
        .lk_refd     (lk_refd),
        .lk_chgd     (lk_chgd),
        .fill_en     (fill_valid),
        .fill_set    (vpn_set(fill_vpn)),
        .fill_ent    (fill_ent),
        .inv_en      (inv_valid),
        .inv_set     (inv_set),
        .touch_en    (good_hit),
        .touch_set   (vpn_set(req_vpn)),
        .touch_way   (lk_way),
        .touch_chg   (is_store)
    );

    always_comb begin
        is_fetch   = (req_kind == ACC_FETCH);
        is_store   = (req_kind == ACC_STORE);
        nx_fault   = is_fetch && seg_rd_nx;
        prot_fault = lk_hit && ((req_user && lk_sup_only) || (is_store && lk_rd_only));
        good_hit   = req_valid && lk_hit && !nx_fault && !prot_fault;

        rsp_d       = '0;
        rsp_d.vld   = req_valid;
        rsp_d.hit   = good_hit;
        rsp_d.fault = req_valid && (nx_fault || prot_fault);
        rsp_d.walk  = req_valid && !lk_hit && !nx_fault;
        rsp_d.vpn   = req_vpn;
        if (good_hit) begin
            rsp_d.pa   = {lk_ppn, req_ea[OFF_W-1:0]};
            rsp_d.upd  = !lk_refd || (is_store && !lk_chgd);
            rsp_d.refd = 1'b1;
            rsp_d.chgd = lk_chgd | is_store;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_fault = rsp_q.fault;
    assign rsp_walk  = rsp_q.walk;
    assign rsp_vpn   = rsp_q.vpn;
    assign rsp_pa    = rsp_q.pa;
    assign rc_upd    = rsp_q.upd;
    assign rc_ref    = rsp_q.refd;
    assign rc_chg    = rsp_q.chgd;

endmodule

// File: rtl/mmu_page_xlate_chk.sv
module mmu_page_xlate_chk
    import mmu_xlate_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [PIDX_W-1:0] req_pidx,
    input logic [OFF_W-1:0]  req_off,
    input logic              seg_nx,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_fault,
    input logic              rsp_walk,
    input logic [VPN_W-1:0]  rsp_vpn,
    input logic [EA_W-1:0]   rsp_pa,
    input logic              rc_upd,
    input logic              rc_ref,
    input logic              rc_chg
);

    a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r1_vpn_page_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_vpn[PIDX_W-1:0] == $past(req_pidx));

    a_r3_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_pa[OFF_W-1:0] == $past(req_off));

    a_r5_walk_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_walk |-> (!rsp_hit && !rsp_fault && rsp_valid));

    a_r6_nx_fetch_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == ACC_FETCH && seg_nx) |=> (rsp_fault && !rsp_walk));

    a_r9_upd_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rc_upd |-> (rsp_hit && rc_ref));

    a_r9_store_sets_chg: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_upd && $past(req_kind) == ACC_STORE) |-> rc_chg);

endmodule

bind mmu_page_xlate mmu_page_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_pidx  (req_ea[27:12]),
    .req_off   (req_ea[11:0]),
    .seg_nx    (seg_rd_nx),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_fault (rsp_fault),
    .rsp_walk  (rsp_walk),
    .rsp_vpn   (rsp_vpn),
    .rsp_pa    (rsp_pa),
    .rc_upd    (rc_upd),
    .rc_ref    (rc_ref),
    .rc_chg    (rc_chg)
);

// File: tb/tb_mmu_page_xlate.sv
`timescale 1ns/100ps
module tb_mmu_page_xlate;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        seg_wr_en;
    logic [3:0]  seg_wr_idx;
    logic [23:0] seg_wr_vsid;
    logic        seg_wr_nx;
    logic        req_valid;
    logic [31:0] req_ea;
    logic [1:0]  req_kind;
    logic        req_user;
    logic        fill_valid;
    logic [39:0] fill_vpn;
    logic [19:0] fill_ppn;
    logic        fill_sup_only;
    logic        fill_rd_only;
    logic        inv_valid;
    logic [5:0]  inv_set;
    logic        rsp_valid, rsp_hit, rsp_fault, rsp_walk;
    logic [39:0] rsp_vpn;
    logic [31:0] rsp_pa;
    logic        rc_upd, rc_ref, rc_chg;

    always #2.5 clk = ~clk;

    mmu_page_xlate dut (.*);

    int n_chk = 0;
    int n_fail = 0;

    // reference model
    logic [23:0] s_vsid [16];
    bit          s_nx   [16];
    bit          m_v    [64][2];
    logic [39:0] m_vpn  [64][2];
    logic [19:0] m_ppn  [64][2];
    bit          m_sup  [64][2];
    bit          m_ro   [64][2];
    bit          m_r    [64][2];
    bit          m_c    [64][2];
    bit          m_lru  [64];

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic idle_in();
        seg_wr_en = 0; seg_wr_idx = '0; seg_wr_vsid = '0; seg_wr_nx = 0;
        req_valid = 0; req_ea = '0; req_kind = '0; req_user = 0;
        fill_valid = 0; fill_vpn = '0; fill_ppn = '0; fill_sup_only = 0; fill_rd_only = 0;
        inv_valid = 0; inv_set = '0;
    endtask

    function automatic bit m_lookup(input logic [39:0] vpn, output int way);
        int s = int'(vpn[7:2]);
        way = 0;
        for (int k = 0; k < 2; k++) begin
            if (m_v[s][k] && m_vpn[s][k] == vpn) begin
                way = k;
                return 1;
            end
        end
        return 0;
    endfunction

    task automatic finish_nonlookup();
        @(negedge clk);
        idle_in();
        chk(rsp_valid == 1'b0, "R2 idle rsp_valid", 64'(rsp_valid), 64'd0);
    endtask

    task automatic do_seg(input int idx, input logic [23:0] vsid, input bit nx);
        seg_wr_en = 1; seg_wr_idx = 4'(idx); seg_wr_vsid = vsid; seg_wr_nx = nx;
        finish_nonlookup();
        s_vsid[idx] = vsid;
        s_nx[idx]   = nx;
    endtask

    task automatic do_fill(input logic [39:0] vpn, input logic [19:0] ppn, input bit sup, input bit ro);
        int s = int'(vpn[7:2]);
        int w;
        fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn; fill_sup_only = sup; fill_rd_only = ro;
        finish_nonlookup();
        if (!m_v[s][0])      w = 0;
        else if (!m_v[s][1]) w = 1;
        else                 w = m_lru[s] ? 1 : 0;
        m_v[s][w] = 1; m_vpn[s][w] = vpn; m_ppn[s][w] = ppn;
        m_sup[s][w] = sup; m_ro[s][w] = ro; m_r[s][w] = 0; m_c[s][w] = 0;
        m_lru[s] = (w == 0);
    endtask

    task automatic do_inv(input int s);
        inv_valid = 1; inv_set = 6'(s);
        finish_nonlookup();
        m_v[s][0] = 0;
        m_v[s][1] = 0;
    endtask

    task automatic do_lk(input logic [31:0] ea, input logic [1:0] kind, input bit user);
        logic [39:0] vpn;
        logic [31:0] epa;
        int  s, w;
        bit  hit, nxf, ef, eh, ew, eu, ec;
        vpn = {s_vsid[ea[31:28]], ea[27:12]};
        s   = int'(ea[19:14]);
        hit = m_lookup(vpn, w);
        nxf = (kind == 2'd0) && s_nx[ea[31:28]];
        ef  = nxf || (hit && ((user && m_sup[s][w]) || (kind == 2'd2 && m_ro[s][w])));
        eh  = hit && !ef;
        ew  = !hit && !nxf;
        epa = {m_ppn[s][w], ea[11:0]};
        ec  = m_c[s][w] | (kind == 2'd2);
        eu  = eh && (!m_r[s][w] || (kind == 2'd2 && !m_c[s][w]));
        req_valid = 1; req_ea = ea; req_kind = kind; req_user = user;
        @(negedge clk);
        idle_in();
        chk(rsp_valid == 1'b1, "R2 rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rsp_vpn == vpn, "R1 rsp_vpn", 64'(rsp_vpn), 64'(vpn));
        chk(rsp_fault == ef, nxf ? "R6 nx fault" : "R7 prot fault", 64'(rsp_fault), 64'(ef));
        chk(rsp_walk == ew, "R5 walk", 64'(rsp_walk), 64'(ew));
        chk(rsp_hit == eh, "R4 hit", 64'(rsp_hit), 64'(eh));
        if (eh) chk(rsp_pa == epa, "R3 pa", 64'(rsp_pa), 64'(epa));
        chk(rc_upd == eu, "R9 rc_upd", 64'(rc_upd), 64'(eu));
        if (eu) chk({rc_ref, rc_chg} == {1'b1, ec}, "R9 rc bits", 64'({rc_ref, rc_chg}), 64'({1'b1, ec}));
        if (eh) begin
            m_r[s][w] = 1;
            m_c[s][w] = ec;
            m_lru[s]  = (w == 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    localparam logic [23:0] VS_A = 24'hA5A5A5;
    localparam logic [31:0] EA_A = 32'h3ABCD123;
    localparam logic [31:0] EA_B = 32'h35BCD456;
    localparam logic [31:0] EA_C = 32'h36BCD789;
    localparam logic [31:0] EA_D = 32'h50001ABC;
    localparam logic [31:0] EA_E = 32'h30002010;

    initial begin
        logic [31:0] ea;
        logic [39:0] vpn;
        int          wdummy;
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) begin s_vsid[i] = '0; s_nx[i] = 0; end
        for (int i = 0; i < 64; i++) begin
            m_lru[i] = 0;
            for (int k = 0; k < 2; k++) begin
                m_v[i][k] = 0; m_vpn[i][k] = '0; m_ppn[i][k] = '0;
                m_sup[i][k] = 0; m_ro[i][k] = 0; m_r[i][k] = 0; m_c[i][k] = 0;
            end
        end
        idle_in();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R11: reset state
        chk({rsp_valid, rsp_hit, rsp_fault, rsp_walk, rc_upd} == 5'b0, "R11 outputs after reset",
            64'({rsp_valid, rsp_hit, rsp_fault, rsp_walk, rc_upd}), 64'd0);
        do_lk(EA_A, 2'd1, 0);
        chk(rsp_walk && rsp_vpn == {24'h0, 16'hABCD}, "R11 empty, zero segment",
            64'(rsp_vpn), 64'({24'h0, 16'hABCD}));

        // R1 + R5: segment substitution on a miss
        do_seg(3, VS_A, 0);
        do_lk(EA_A, 2'd1, 0);
        chk(rsp_vpn == {VS_A, 16'hABCD}, "R1 segment id substituted", 64'(rsp_vpn), 64'({VS_A, 16'hABCD}));

        // R3 + R9: refill, hit, referenced then changed once
        do_fill({VS_A, EA_A[27:12]}, 20'h11111, 0, 0);
        do_lk(EA_A, 2'd1, 0);
        chk(rsp_pa == 32'h11111123, "R3 hit address", 64'(rsp_pa), 64'h11111123);
        chk(rc_upd && rc_ref && !rc_chg, "R9 first hit sets ref", 64'({rc_upd, rc_ref, rc_chg}), 64'b110);
        do_lk(EA_A, 2'd2, 0);
        chk(rc_upd && rc_chg, "R9 first store sets chg", 64'({rc_upd, rc_chg}), 64'b11);
        do_lk(EA_A, 2'd2, 0);
        chk(!rc_upd, "R9 second store no strobe", 64'(rc_upd), 64'd0);

        // R4 + R8: second way, then least recently used eviction
        do_fill({VS_A, EA_B[27:12]}, 20'h22222, 0, 0);
        do_lk(EA_A, 2'd1, 0);
        do_lk(EA_B, 2'd1, 0);
        chk(rsp_hit && rsp_pa == 32'h22222456, "R4 both ways resident", 64'(rsp_pa), 64'h22222456);
        do_fill({VS_A, EA_C[27:12]}, 20'h33333, 0, 0);
        do_lk(EA_A, 2'd1, 0);
        chk(rsp_walk, "R8 least recent way evicted", 64'(rsp_walk), 64'd1);
        do_lk(EA_B, 2'd1, 0);
        chk(rsp_hit, "R8 recent way kept", 64'(rsp_hit), 64'd1);
        do_lk(EA_C, 2'd0, 0);

        // R6: no-execute segment
        do_seg(5, 24'h123456, 1);
        do_lk(EA_D, 2'd0, 0);
        chk(rsp_fault && !rsp_walk, "R6 nx fetch on miss", 64'({rsp_fault, rsp_walk}), 64'b10);
        do_lk(EA_D, 2'd1, 0);
        chk(rsp_walk && !rsp_fault, "R6 nx load walks", 64'({rsp_fault, rsp_walk}), 64'b01);
        do_fill({24'h123456, EA_D[27:12]}, 20'h44444, 0, 0);
        do_lk(EA_D, 2'd0, 0);
        chk(rsp_fault && !rsp_hit, "R6 nx fetch on hit", 64'({rsp_fault, rsp_hit}), 64'b10);
        do_lk(EA_D, 2'd1, 0);

        // R7: privilege and read-only faults leave state untouched
        do_fill({VS_A, EA_E[27:12]}, 20'h55555, 1, 1);
        do_lk(EA_E, 2'd1, 1);
        chk(rsp_fault && !rc_upd, "R7 user on supervisor page", 64'({rsp_fault, rc_upd}), 64'b10);
        do_lk(EA_E, 2'd1, 0);
        chk(rc_upd && rc_ref, "R7 faulted access left ref clear", 64'({rc_upd, rc_ref}), 64'b11);
        do_lk(EA_E, 2'd2, 0);
        chk(rsp_fault && !rc_upd, "R7 store to read-only", 64'({rsp_fault, rc_upd}), 64'b10);

        // R10: invalidate both ways
        do_inv(int'(EA_B[19:14]));
        do_lk(EA_B, 2'd1, 0);
        chk(rsp_walk, "R10 way gone after invalidate", 64'(rsp_walk), 64'd1);
        do_lk(EA_C, 2'd1, 0);
        chk(rsp_walk, "R10 other way gone", 64'(rsp_walk), 64'd1);
        do_lk(EA_E, 2'd1, 0);
        chk(rsp_hit, "R10 other set untouched", 64'(rsp_hit), 64'd1);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom % 100);
            ea = {4'($urandom), 6'd0, 2'($urandom), 4'd0, 2'($urandom), 2'($urandom), 12'($urandom)};
            vpn = {s_vsid[ea[31:28]], ea[27:12]};
            if (r < 60) begin
                do_lk(ea, 2'($urandom % 3), bit'($urandom));
            end else if (r < 85) begin
                if (!m_lookup(vpn, wdummy))
                    do_fill(vpn, 20'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0);
                else
                    do_lk(ea, 2'd2, 0);
            end else if (r < 92) begin
                do_inv(int'(ea[19:14]));
            end else begin
                do_seg(int'(ea[31:28]), {20'h0, 4'($urandom % 4)} * 24'h111111, ($urandom % 4) == 0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule